// File: doc/BRIEF.md
# Nibble-Written Bank Register File

This block holds the bank-select state for one mode of a cartridge memory mapper. The CPU reaches it through a write-only address-decoded bus. It keeps eight 8-bit character-bank registers, two 8-bit program-bank registers and one mirroring bit. Each character register is loaded four bits at a time. The write address chooses the register and also chooses which half of it is replaced.

From these registers the block produces three outputs, all combinational. The first is eight 9-bit character bank numbers for 1 KB pages. The second is four 8-bit program bank numbers for 8 KB windows. The third is a mirroring select. An outer base bit, taken from bit 2 of the mapper's mode byte, becomes bit 8 of every character bank number. A register write takes effect on the clock edge where the write strobe is high.

Top module: `nibble_bank_regs`

## Requirements
- R1: While reset is held, and after it is released with no writes, the character registers 0 to 3 read 0xFF and the character registers 4 to 7 read 4, 5, 6 and 7. Program registers 0 and 1 read 0 and 1, the stored mirroring bit is 0, and so mirror_sel is 1.
- R2: A write with an address from 0xB000 to 0xE003 inclusive targets one character register. The upper address nibble picks a pair: 0xB gives registers 0/1, 0xC gives 2/3, 0xD gives 4/5 and 0xE gives 6/7. Within the pair, the odd register is chosen when address bit 1 or address bit 11 is set.
- R3: For a character write with address bit 0 clear, data bits 3:0 replace bits 3:0 of the target register, and bits 7:4 are kept.
- R4: For a character write with address bit 0 set, data bits 3:0 replace bits 7:4 of the target register, and bits 3:0 are kept.
- R5: A write whose address bits 15:12 equal 0x8 loads the whole data byte into program register 0. A write whose address bits 15:12 equal 0xA loads it into program register 1.
- R6: A write whose address bits 15:12 equal 0x9 stores data bit 0 as the mirroring bit. mirror_sel is the inverse of the stored bit.
- R7: prg_bank_flat holds four 8-bit windows, with window w at bits 8w+7:8w. Windows 0 and 1 are program registers 0 and 1. Window 2 is always 0xFE and window 3 is always 0xFF.
- R8: chr_bank_flat holds eight 9-bit banks, with bank i at bits 9i+8:9i. Bits 7:0 of bank i are character register i, and bit 8 follows chr_base_hi combinationally, with no clock edge needed.
- R9: A write to any other address changes no output. This covers addresses below 0x8000, 0xE004 to 0xEFFF and 0xF000 and above. A cycle with wr_en low also changes no output, whatever the address and data are.
- R10: A write becomes visible on the outputs right after the rising clock edge at which wr_en is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| chr_base_hi | input | 1 | Outer character base bit (bit 2 of the mode byte) |
| chr_bank_flat | output | 72 | Eight 9-bit 1 KB character bank numbers |
| prg_bank_flat | output | 32 | Four 8-bit 8 KB program bank numbers |
| mirror_sel | output | 1 | Mirroring select, the inverse of the stored bit |

## Verification
The assertions assume a clean bus. They take wr_en, wr_addr and wr_data to be known and stable at each rising edge, with no writes reaching the register file while the internal synchronized reset is still active. The stimulus changes inputs only on falling edges. It waits several cycles after rst_n rises before it issues the first write. It draws random addresses from each decoded region and from the whole 16-bit space, and it adds cycles that present valid addresses and data with wr_en low.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
  localparam int CHR_REGS    = 8;
  localparam int PRG_REGS    = 2;
  localparam int PRG_WINDOWS = 4;
  localparam int CHR_IDX_W   = $clog2(CHR_REGS);

  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_CHR  = 2'd1,
    WK_PRG  = 2'd2,
    WK_MIR  = 2'd3
  } wr_kind_e;

  // Reset value of character register idx (R1)
  function automatic logic [7:0] chr_reset_val(input int idx);
    return (idx < 4) ? 8'hFF : 8'(idx);
  endfunction
endpackage

// File: rtl/nbr_rst_sync.sv
module nbr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/nbr_addr_decode.sv
module nbr_addr_decode
  import nbr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  output wr_kind_e             kind,
  output logic [CHR_IDX_W-1:0] chr_idx,
  output logic                 hi_nib,
  output logic                 prg_sel
);
  localparam logic [ADDR_W-1:0] CHR_LO = ADDR_W'(16'hB000);
  localparam logic [ADDR_W-1:0] CHR_HI = ADDR_W'(16'hE003);

  logic                 in_chr;
  logic [3:0]           page;
  logic [CHR_IDX_W-1:0] raw_idx;

  always_comb begin
    in_chr  = (addr >= CHR_LO) && (addr <= CHR_HI);
    page    = addr[15:12];
    // Scattered address bits form the index, rotated by two
    raw_idx = {addr[13], addr[12], addr[1] | addr[11]};
    chr_idx = raw_idx + CHR_IDX_W'(2);
    hi_nib  = addr[0];
    prg_sel = (page == 4'hA);
    kind    = WK_NONE;
    if (wr_en) begin
      if (in_chr)                              kind = WK_CHR;
      else if (page == 4'h8 || page == 4'hA)   kind = WK_PRG;
      else if (page == 4'h9)                   kind = WK_MIR;
    end
  end
endmodule

// File: rtl/nbr_chr_file.sv
module nbr_chr_file
  import nbr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = DATA_W / 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [CHR_IDX_W-1:0]       idx,
  input  logic                       hi_nib,
  input  logic [NIB_W-1:0]           nib,
  output logic [CHR_REGS*DATA_W-1:0] regs_flat
);
  for (genvar g = 0; g < CHR_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] q, d;
    logic              en;

    always_comb begin
      en = wr && (idx == CHR_IDX_W'(g));
      d  = q;
      if (hi_nib) d[DATA_W-1:NIB_W] = nib;
      else        d[NIB_W-1:0]      = nib;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= DATA_W'(chr_reset_val(g));
      else if (en) q <= d;
    end

    assign regs_flat[g*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/nbr_prg_file.sv
module nbr_prg_file
  import nbr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_prg,
  input  logic                       prg_sel,
  input  logic                       wr_mir,
  input  logic [DATA_W-1:0]          data,
  output logic [PRG_REGS*DATA_W-1:0] prg_flat,
  output logic                       mir_bit
);
  for (genvar g = 0; g < PRG_REGS; g++) begin : g_prg
    logic [DATA_W-1:0] q;
    logic              en;

    assign en = wr_prg && (prg_sel == (g != 0));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= DATA_W'(g);
      else if (en) q <= data;
    end

    assign prg_flat[g*DATA_W +: DATA_W] = q;
  end

  logic mir_d;
  assign mir_d = wr_mir ? data[0] : mir_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mir_bit <= 1'b0;
    else        mir_bit <= mir_d;
  end
endmodule

// File: rtl/nibble_bank_regs.sv
module nibble_bank_regs
  import nbr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NIB_W  = DATA_W / 2,
  localparam int CHR_BANK_W = DATA_W + 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [DATA_W-1:0]               wr_data,
  input  logic                            chr_base_hi,
  output logic [CHR_REGS*CHR_BANK_W-1:0]  chr_bank_flat,
  output logic [PRG_WINDOWS*DATA_W-1:0]   prg_bank_flat,
  output logic                            mirror_sel
);
  logic                       core_rst_n;
  wr_kind_e                   kind;
  logic [CHR_IDX_W-1:0]       chr_idx;
  logic                       hi_nib, prg_sel, mir_bit;
  logic [CHR_REGS*DATA_W-1:0] chr_regs;
  logic [PRG_REGS*DATA_W-1:0] prg_regs;

  nbr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  nbr_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en   (wr_en),
    .addr    (wr_addr),
    .kind    (kind),
    .chr_idx (chr_idx),
    .hi_nib  (hi_nib),
    .prg_sel (prg_sel)
  );

  nbr_chr_file #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_chr (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .wr        (kind == WK_CHR),
    .idx       (chr_idx),
    .hi_nib    (hi_nib),
    .nib       (wr_data[NIB_W-1:0]),
    .regs_flat (chr_regs)
  );

  nbr_prg_file #(.DATA_W(DATA_W)) u_prg (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .wr_prg   (kind == WK_PRG),
    .prg_sel  (prg_sel),
    .wr_mir   (kind == WK_MIR),
    .data     (wr_data),
    .prg_flat (prg_regs),
    .mir_bit  (mir_bit)
  );

  for (genvar g = 0; g < CHR_REGS; g++) begin : g_chr_out
    assign chr_bank_flat[g*CHR_BANK_W +: CHR_BANK_W] =
      {chr_base_hi, chr_regs[g*DATA_W +: DATA_W]};
  end

  for (genvar w = 0; w < PRG_WINDOWS; w++) begin : g_prg_out
    if (w < PRG_REGS) begin : g_reg
      assign prg_bank_flat[w*DATA_W +: DATA_W] = prg_regs[w*DATA_W +: DATA_W];
    end else begin : g_fixed
      // Fixed windows count back from the last bank
      assign prg_bank_flat[w*DATA_W +: DATA_W] =
        ~DATA_W'(PRG_WINDOWS - 1 - w);
    end
  end

  assign mirror_sel = ~mir_bit;
endmodule

// File: rtl/nbr_checker.sv
module nbr_checker
  import nbr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int CHR_BANK_W = DATA_W + 1
) (
  input logic                           clk,
  input logic                           core_rst_n,
  input logic                           wr_en,
  input logic [ADDR_W-1:0]              wr_addr,
  input logic [DATA_W-1:0]              wr_data,
  input logic                           chr_base_hi,
  input logic [CHR_REGS*CHR_BANK_W-1:0] chr_bank_flat,
  input logic [PRG_WINDOWS*DATA_W-1:0]  prg_bank_flat,
  input logic                           mirror_sel
);
  AST_PRG0_LOAD: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_en && wr_addr[15:12] == 4'h8) |=> prg_bank_flat[DATA_W-1:0] == $past(wr_data)); // R5
  AST_PRG1_LOAD: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_en && wr_addr[15:12] == 4'hA) |=> prg_bank_flat[2*DATA_W-1:DATA_W] == $past(wr_data)); // R5
  AST_MIRROR_LOAD: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_en && wr_addr[15:12] == 4'h9) |=> mirror_sel == !$past(wr_data[0])); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!core_rst_n)
    !wr_en |=> $stable(prg_bank_flat) && $stable(mirror_sel)); // R9
  AST_FIXED_WINDOWS: assert property (@(posedge clk) disable iff (!core_rst_n)
    prg_bank_flat[PRG_WINDOWS*DATA_W-1:2*DATA_W] == {{DATA_W{1'b1}}, {(DATA_W-1){1'b1}}, 1'b0}); // R7

  for (genvar g = 0; g < CHR_REGS; g++) begin : g_base
    AST_BASE_BIT: assert property (@(posedge clk) disable iff (!core_rst_n)
      chr_bank_flat[g*CHR_BANK_W + DATA_W] == chr_base_hi); // R8
  end
endmodule

bind nibble_bank_regs nbr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .core_rst_n    (core_rst_n),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .wr_data       (wr_data),
  .chr_base_hi   (chr_base_hi),
  .chr_bank_flat (chr_bank_flat),
  .prg_bank_flat (prg_bank_flat),
  .mirror_sel    (mirror_sel)
);

// File: tb/nibble_bank_regs_test.sv
module nibble_bank_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        chr_base_hi = 1'b0;
  logic [71:0] chr_bank_flat;
  logic [31:0] prg_bank_flat;
  logic        mirror_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_chr [8];
  logic [7:0] m_prg [2];
  logic       m_mir;

  always #(CLK_PERIOD/2) clk = ~clk;

  nibble_bank_regs uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .chr_base_hi(chr_base_hi),
    .chr_bank_flat(chr_bank_flat), .prg_bank_flat(prg_bank_flat),
    .mirror_sel(mirror_sel)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_chr[i] = (i < 4) ? 8'hFF : 8'(i);
    m_prg[0] = 8'd0;
    m_prg[1] = 8'd1;
    m_mir    = 1'b0;
  endtask

  // Model of one write, built from R2..R6 and R9
  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    int pair;
    int idx;
    if (a >= 16'hB000 && a <= 16'hE003) begin
      case (a[15:12])
        4'hB: pair = 0;
        4'hC: pair = 1;
        4'hD: pair = 2;
        default: pair = 3;
      endcase
      idx = 2 * pair + int'(a[1] | a[11]);
      if (a[0]) m_chr[idx] = {d[3:0], m_chr[idx][3:0]};
      else      m_chr[idx] = {m_chr[idx][7:4], d[3:0]};
    end else if (a[15:12] == 4'h8) m_prg[0] = d;
    else if (a[15:12] == 4'hA)     m_prg[1] = d;
    else if (a[15:12] == 4'h9)     m_mir = d[0];
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 8; i++)
      check(req, $sformatf("chr bank %0d", i),
            32'(chr_bank_flat[i*9 +: 9]), 32'({chr_base_hi, m_chr[i]}));
    check(req, "prg window 0", 32'(prg_bank_flat[7:0]),   32'(m_prg[0]));
    check(req, "prg window 1", 32'(prg_bank_flat[15:8]),  32'(m_prg[1]));
    check("R7", "prg window 2", 32'(prg_bank_flat[23:16]), 32'hFE);
    check("R7", "prg window 3", 32'(prg_bank_flat[31:24]), 32'hFF);
    check(req, "mirror_sel", 32'(mirror_sel), 32'(!m_mir));
  endtask

  // One bus cycle; outputs checked at the next falling edge (R10)
  task automatic bus(input logic en, input logic [15:0] a,
                     input logic [7:0] d, input string req);
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (en) model_write(a, d);
    #1 check_all(req);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    #1 check_all("R1");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    #1 check_all("R1");

    // R3 / R4: low then high nibble of register 0, upper data bits ignored
    bus(1'b1, 16'hB000, 8'hA5, "R3");
    bus(1'b1, 16'hB001, 8'hFC, "R4");
    // R2: odd register selected by bit 1 and by bit 11
    bus(1'b1, 16'hB002, 8'h03, "R2");
    bus(1'b1, 16'hC800, 8'h09, "R2");
    bus(1'b1, 16'hD003, 8'h0E, "R2");
    bus(1'b1, 16'hE003, 8'h07, "R2");
    bus(1'b1, 16'hE000, 8'h01, "R2");
    // R9: outside the decoded ranges
    bus(1'b1, 16'hE004, 8'h55, "R9");
    bus(1'b1, 16'hF000, 8'h55, "R9");
    bus(1'b1, 16'h7FFF, 8'h55, "R9");
    bus(1'b0, 16'h8000, 8'h77, "R9");
    // R5 / R6
    bus(1'b1, 16'h8000, 8'h3C, "R5");
    bus(1'b1, 16'hA123, 8'hC3, "R5");
    bus(1'b1, 16'h9FFF, 8'h01, "R6");
    bus(1'b1, 16'h9000, 8'hFE, "R6");
    // R8: base bit follows the input with no clock edge
    chr_base_hi = 1'b1;
    #1 check_all("R8");
    chr_base_hi = 1'b0;
    #1 check_all("R8");

    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      logic [7:0]  d;
      int region;
      region = int'($urandom % 6);
      d = 8'($urandom);
      a = 16'($urandom);
      case (region)
        0: begin
          a[15:12] = 4'hB + 4'($urandom % 4);
          if (a[15:12] == 4'hE) a[11:2] = '0;
        end
        1: a[15:12] = 4'h8;
        2: a[15:12] = 4'hA;
        3: a[15:12] = 4'h9;
        default: ;
      endcase
      chr_base_hi = 1'($urandom);
      bus(region != 5, a, d, "R10");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule